// File: doc/BRIEF.md
# S/PDIF Transmit Source FIFO Controller

This block sits between a processor write port and a serial digital-audio frame transmitter. It buffers outgoing 24-bit samples in a small FIFO and hands one sample to the transmitter each time the transmitter raises its sample-request strobe. The sample source is chosen by a 4-bit select field. It can be processor writes, a constant digital zero, or a copy of one of four incoming receive channels.

The FIFO has a reset state that is controlled by software. While the FIFO is held in that state, it looks like a queue holding one all-zero sample. When software clears the reset bit, the FIFO stays in reset until the first sample arrives from the selected source. This ties the start of transmission to the first data write. The FIFO has two sticky error flags. One marks an underrun, and on underrun the last sample is repeated. The other marks an overrun, and the excess write is dropped.

Three further parts of the configuration act on the output side. The validity flag goes out with every sample. The user-channel bit is taken from a selected source. A 3-bit output selector picks what reaches the serial output pin: off, a raw copy of one of four serial inputs, or the formatted transmitter stream. Biphase coding, preambles and channel-status assembly belong to the transmitter and are not part of this block.

Top module: `spdif_src_ctrl`

## Requirements
- R1: After reset `in_rst_o`=1, `smp_o`=0, `urun_o`=0, `orun_o`=0 and `ser_o`=0, and the source is processor (code 4'h0).
- R2: While the FIFO reset bit is 1, a sample request returns 0 one cycle later on `smp_o` (with `smp_stb_o`=1), and sample writes are discarded.
- R3: After a configuration write clears the reset bit, `in_rst_o` stays 1 until the first sample from the selected source is written. From then on, requests return first the zero sample and then the written samples in write order.
- R4: The FIFO holds 4 samples, and the preloaded zero sample counts as one of them. A write while 4 are held is dropped and sets `orun_o`, which stays set until a cycle with `clr_orun_i`=1.
- R5: A request while the FIFO is empty in normal operation sets `urun_o` (sticky until `clr_urun_i`) and repeats the previous sample. No entry is consumed, so the next write is the next sample returned.
- R6: With source code 4'h1 (digital zero), every returned sample is 0, the FIFO is not read, and neither `urun_o` nor `orun_o` is set.
- R7: A configuration write changes the source field only if the FIFO is in reset or the same write sets the reset bit. Otherwise `src_o` keeps its value.
- R8: Source codes 4'b10cc copy receive channel cc. Only `rx_stb_i[cc]` writes a sample (`rx_smp_i[cc*24 +: 24]`), and processor writes and strobes of other channels are ignored. All other undefined codes act as digital zero.
- R9: `v_o` follows the validity-control bit with each sample: control 0 gives `v_o`=0 (valid), and control 1 gives `v_o`=1 (invalid).
- R10: User select `u_sel`: 2'b00 gives `u_o`=0, 2'b01 gives `u_rx_i`, 2'b10 (reserved) gives 0, and 2'b11 gives `u_gen_i`.
- R11: Output select: 3'b000 gives `ser_o`=0, 3'b001 to 3'b100 give `ser_in_i[code-1]`, 3'b101 gives `tx_ser_i`, and 3'b110 and 3'b111 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Configuration write strobe |
| ctl_fifo_rst_i | input | 1 | FIFO reset bit value to write |
| ctl_src_i | input | 4 | Source select to write |
| ctl_vinv_i | input | 1 | Validity control (1 = mark invalid) |
| ctl_usel_i | input | 2 | User-channel source select |
| ctl_osel_i | input | 3 | Serial output select |
| dat_we_i | input | 1 | Processor sample write strobe |
| dat_i | input | 24 | Processor sample |
| rx_stb_i | input | 4 | Per-channel receive sample strobe |
| rx_smp_i | input | 96 | Receive samples, channel k at [k*24 +: 24] |
| req_i | input | 1 | Transmitter sample request |
| clr_urun_i | input | 1 | Clear underrun flag |
| clr_orun_i | input | 1 | Clear overrun flag |
| u_rx_i | input | 1 | User bit from receive path |
| u_gen_i | input | 1 | User bit from on-chip generator |
| ser_in_i | input | 4 | Raw serial inputs for pass-through |
| tx_ser_i | input | 1 | Formatted transmitter serial stream |
| smp_o | output | 24 | Sample delivered to transmitter |
| smp_stb_o | output | 1 | Sample-valid strobe, one cycle after request |
| v_o | output | 1 | Validity flag for delivered sample |
| u_o | output | 1 | Selected user-channel bit |
| ser_o | output | 1 | Serial output pin |
| urun_o | output | 1 | Sticky underrun flag |
| orun_o | output | 1 | Sticky overrun flag |
| in_rst_o | output | 1 | FIFO is in its reset state |
| src_o | output | 4 | Active source select |

## Verification
The hardest state to reach is the exact FIFO boundary, because the zero sample loaded by reset silently takes one slot. The stimulus releases the FIFO with one write and then adds exactly two more to fill it. A further write then has to raise the overrun. Draining past the last entry produces an underrun, and a fresh write afterwards shows that the read pointer did not advance while the FIFO was empty. The release condition for the copy source is reached by offering processor writes and strobes from a wrong channel before the strobe of the selected channel. In each case the bench confirms that the FIFO stays in reset until that selected strobe.

// File: rtl/spdif_src_pkg.sv
`timescale 1ns/1ps
package spdif_src_pkg;
  localparam logic [3:0] SRC_PROC = 4'h0;
  localparam logic [3:0] SRC_ZERO = 4'h1;

  localparam logic [2:0] OSEL_OFF = 3'b000;
  localparam logic [2:0] OSEL_TX  = 3'b101;

  localparam logic [1:0] USEL_NONE = 2'b00;
  localparam logic [1:0] USEL_RX   = 2'b01;
  localparam logic [1:0] USEL_GEN  = 2'b11;

  function automatic logic src_is_copy(logic [3:0] s);
    return s[3:2] == 2'b10;
  endfunction

  function automatic logic src_is_zero(logic [3:0] s);
    return (s != SRC_PROC) && !src_is_copy(s);
  endfunction
endpackage

// File: rtl/spdif_src_fifo.sv
`timescale 1ns/1ps
module spdif_src_fifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = cnt_q == CW'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  // Reset state: one zero sample at slot 0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q  <= '0;
      wp_q  <= AW'(1);
      cnt_q <= CW'(1);
    end else if (clr_i) begin
      rp_q  <= '0;
      wp_q  <= AW'(1);
      cnt_q <= CW'(1);
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      mem_q[0] <= '0;
    end else if (do_wr) begin
      mem_q[wp_q] <= wdata_i;
    end
  end
endmodule

// File: rtl/spdif_src_cfg.sv
`timescale 1ns/1ps
module spdif_src_cfg
  import spdif_src_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic       ctl_fifo_rst_i,
  input  logic [3:0] ctl_src_i,
  input  logic       ctl_vinv_i,
  input  logic [1:0] ctl_usel_i,
  input  logic [2:0] ctl_osel_i,
  input  logic       wr_evt_i,
  output logic       rst_bit_o,
  output logic       hold_o,
  output logic       in_rst_o,
  output logic [3:0] src_o,
  output logic       vinv_o,
  output logic [1:0] usel_o,
  output logic [2:0] osel_o
);
  logic       rst_q, hold_q, vinv_q;
  logic [3:0] src_q;
  logic [1:0] usel_q;
  logic [2:0] osel_q;
  logic       src_ok;

  assign in_rst_o = rst_q | hold_q;
  assign src_ok   = in_rst_o | ctl_fifo_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b1;
      hold_q <= 1'b0;
      src_q  <= SRC_PROC;
      vinv_q <= 1'b0;
      usel_q <= USEL_NONE;
      osel_q <= OSEL_OFF;
    end else if (ctl_we_i) begin
      rst_q  <= ctl_fifo_rst_i;
      // Leaving reset parks in hold until the first sample arrives.
      hold_q <= !ctl_fifo_rst_i && in_rst_o;
      if (src_ok) src_q <= ctl_src_i;
      vinv_q <= ctl_vinv_i;
      usel_q <= ctl_usel_i;
      osel_q <= ctl_osel_i;
    end else if (hold_q && !rst_q && wr_evt_i) begin
      hold_q <= 1'b0;
    end
  end

  assign rst_bit_o = rst_q;
  assign hold_o    = hold_q;
  assign src_o     = src_q;
  assign vinv_o    = vinv_q;
  assign usel_o    = usel_q;
  assign osel_o    = osel_q;
endmodule

// File: rtl/spdif_src_omux.sv
`timescale 1ns/1ps
module spdif_src_omux
  import spdif_src_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [2:0]     osel_i,
  input  logic [1:0]     usel_i,
  input  logic [NCH-1:0] ser_in_i,
  input  logic           tx_ser_i,
  input  logic           u_rx_i,
  input  logic           u_gen_i,
  output logic           ser_o,
  output logic           u_o
);
  always_comb begin
    ser_o = 1'b0;
    if (osel_i == OSEL_TX) ser_o = tx_ser_i;
    for (int k = 0; k < NCH; k++) begin
      if (osel_i == 3'(k + 1)) ser_o = ser_in_i[k];
    end
  end

  always_comb begin
    unique case (usel_i)
      USEL_RX:  u_o = u_rx_i;
      USEL_GEN: u_o = u_gen_i;
      default:  u_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spdif_src_ctrl.sv
`timescale 1ns/1ps
module spdif_src_ctrl
  import spdif_src_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 4,
  parameter int NCH   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             ctl_fifo_rst_i,
  input  logic [3:0]       ctl_src_i,
  input  logic             ctl_vinv_i,
  input  logic [1:0]       ctl_usel_i,
  input  logic [2:0]       ctl_osel_i,
  input  logic             dat_we_i,
  input  logic [DW-1:0]    dat_i,
  input  logic [NCH-1:0]   rx_stb_i,
  input  logic [NCH*DW-1:0] rx_smp_i,
  input  logic             req_i,
  input  logic             clr_urun_i,
  input  logic             clr_orun_i,
  input  logic             u_rx_i,
  input  logic             u_gen_i,
  input  logic [NCH-1:0]   ser_in_i,
  input  logic             tx_ser_i,
  output logic [DW-1:0]    smp_o,
  output logic             smp_stb_o,
  output logic             v_o,
  output logic             u_o,
  output logic             ser_o,
  output logic             urun_o,
  output logic             orun_o,
  output logic             in_rst_o,
  output logic [3:0]       src_o
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          rst_bit, hold, in_rst, vinv_q;
  logic [3:0]    src_q;
  logic [1:0]    usel_q;
  logic [2:0]    osel_q;
  logic          is_zero, is_copy;
  logic [CHW-1:0] chan;
  logic          wr_evt;
  logic [DW-1:0] wr_data;
  logic          f_clr, f_wr, f_rd, f_empty, f_full;
  logic [DW-1:0] f_rdata;
  logic [DW-1:0] smp_q;
  logic          stb_q, v_q, urun_q, orun_q;
  logic          urun_set, orun_set;

  assign is_zero = src_is_zero(src_q);
  assign is_copy = src_is_copy(src_q);
  assign chan    = CHW'(src_q[1:0]);

  always_comb begin
    wr_evt  = 1'b0;
    wr_data = dat_i;
    if (is_copy) begin
      if (int'(chan) < NCH) begin
        wr_evt  = rx_stb_i[chan];
        wr_data = rx_smp_i[int'(chan)*DW +: DW];
      end
    end else begin
      wr_evt = dat_we_i;
    end
  end

  spdif_src_cfg u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctl_we_i       (ctl_we_i),
    .ctl_fifo_rst_i (ctl_fifo_rst_i),
    .ctl_src_i      (ctl_src_i),
    .ctl_vinv_i     (ctl_vinv_i),
    .ctl_usel_i     (ctl_usel_i),
    .ctl_osel_i     (ctl_osel_i),
    .wr_evt_i       (wr_evt),
    .rst_bit_o      (rst_bit),
    .hold_o         (hold),
    .in_rst_o       (in_rst),
    .src_o          (src_q),
    .vinv_o         (vinv_q),
    .usel_o         (usel_q),
    .osel_o         (osel_q)
  );

  // Release write lands in the slot after the zero sample.
  assign f_clr = rst_bit | (hold & !wr_evt) | ctl_we_i & ctl_fifo_rst_i;
  assign f_wr  = wr_evt & !rst_bit & !ctl_we_i;
  assign f_rd  = req_i & !in_rst & !is_zero;

  spdif_src_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (f_clr),
    .wr_i    (f_wr),
    .wdata_i (wr_data),
    .rd_i    (f_rd),
    .rdata_o (f_rdata),
    .empty_o (f_empty),
    .full_o  (f_full)
  );

  assign urun_set = f_rd & f_empty;
  assign orun_set = f_wr & f_full & !in_rst & !is_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      stb_q  <= 1'b0;
      v_q    <= 1'b0;
      urun_q <= 1'b0;
      orun_q <= 1'b0;
    end else begin
      stb_q  <= req_i;
      if (req_i) begin
        v_q <= vinv_q;
        if (in_rst || is_zero) smp_q <= '0;
        else if (!f_empty)     smp_q <= f_rdata;
      end
      urun_q <= (urun_q & !clr_urun_i) | urun_set;
      orun_q <= (orun_q & !clr_orun_i) | orun_set;
    end
  end

  spdif_src_omux #(.NCH(NCH)) u_omux (
    .osel_i   (osel_q),
    .usel_i   (usel_q),
    .ser_in_i (ser_in_i),
    .tx_ser_i (tx_ser_i),
    .u_rx_i   (u_rx_i),
    .u_gen_i  (u_gen_i),
    .ser_o    (ser_o),
    .u_o      (u_o)
  );

  assign smp_o     = smp_q;
  assign smp_stb_o = stb_q;
  assign v_o       = v_q;
  assign urun_o    = urun_q;
  assign orun_o    = orun_q;
  assign in_rst_o  = in_rst;
  assign src_o     = src_q;
endmodule

// File: rtl/spdif_src_chk.sv
`timescale 1ns/1ps
module spdif_src_chk
  import spdif_src_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_rst_o,
  input logic [3:0]    src_o,
  input logic [DW-1:0] smp_o,
  input logic          smp_stb_o,
  input logic          urun_o,
  input logic          orun_o,
  input logic          clr_urun_i,
  input logic          clr_orun_i,
  input logic [2:0]    osel_i,
  input logic          ser_o
);
  AST_RST_SAMPLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_o && $past(in_rst_o) |-> smp_o == '0); // R2

  AST_SRC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rst_o && $past(!in_rst_o) |-> $stable(src_o)); // R7

  AST_ZERO_SRC_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_o && src_is_zero($past(src_o)) |-> smp_o == '0); // R6

  AST_ZERO_SRC_NO_URUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_is_zero(src_o) && src_is_zero($past(src_o)) && !$past(in_rst_o) |-> !$rose(urun_o)); // R6

  AST_URUN_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(urun_o) |-> $stable(smp_o)); // R5

  AST_URUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(urun_o) && !$past(clr_urun_i) |-> urun_o); // R5

  AST_ORUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(orun_o) && !$past(clr_orun_i) |-> orun_o); // R4

  AST_OUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osel_i == OSEL_OFF || osel_i > OSEL_TX) |-> !ser_o); // R11
endmodule

bind spdif_src_ctrl spdif_src_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_rst_o   (in_rst_o),
  .src_o      (src_o),
  .smp_o      (smp_o),
  .smp_stb_o  (smp_stb_o),
  .urun_o     (urun_o),
  .orun_o     (orun_o),
  .clr_urun_i (clr_urun_i),
  .clr_orun_i (clr_orun_i),
  .osel_i     (osel_q),
  .ser_o      (ser_o)
);

// File: tb/sim_spdif_src_ctrl.sv
`timescale 1ns/1ps
module sim_spdif_src_ctrl;
  localparam int DW  = 24;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_rst = 1;
  logic [3:0] ctl_src = 4'h0;
  logic ctl_vinv = 0;
  logic [1:0] ctl_usel = 0;
  logic [2:0] ctl_osel = 0;
  logic dat_we = 0;
  logic [DW-1:0] dat = '0;
  logic [NCH-1:0] rx_stb = '0;
  logic [NCH*DW-1:0] rx_smp = '0;
  logic req = 0, clr_u = 0, clr_o = 0, u_rx = 0, u_gen = 0, tx_ser = 0;
  logic [NCH-1:0] ser_in = '0;
  logic [DW-1:0] smp;
  logic smp_stb, v, u, ser, urun, orun, in_rst;
  logic [3:0] src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spdif_src_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_fifo_rst_i(ctl_rst),
    .ctl_src_i(ctl_src), .ctl_vinv_i(ctl_vinv), .ctl_usel_i(ctl_usel),
    .ctl_osel_i(ctl_osel), .dat_we_i(dat_we), .dat_i(dat), .rx_stb_i(rx_stb),
    .rx_smp_i(rx_smp), .req_i(req), .clr_urun_i(clr_u), .clr_orun_i(clr_o),
    .u_rx_i(u_rx), .u_gen_i(u_gen), .ser_in_i(ser_in), .tx_ser_i(tx_ser),
    .smp_o(smp), .smp_stb_o(smp_stb), .v_o(v), .u_o(u), .ser_o(ser),
    .urun_o(urun), .orun_o(orun), .in_rst_o(in_rst), .src_o(src)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(bit r, logic [3:0] s);
    ctl_rst = r; ctl_src = s; ctl_we = 1;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic pwr(logic [DW-1:0] d);
    dat = d; dat_we = 1;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rq();
    req = 1;
    @(negedge clk); req = 0;
  endtask

  task automatic clr_flags();
    clr_u = 1; clr_o = 1;
    @(negedge clk); clr_u = 0; clr_o = 0;
  endtask

  task automatic t_reset();
    chk("R1 in_rst", 32'(in_rst), 1);
    chk("R1 smp", 32'(smp), 0);
    chk("R1 urun", 32'(urun), 0);
    chk("R1 orun", 32'(orun), 0);
    chk("R1 ser", 32'(ser), 0);
    chk("R1 src", 32'(src), 0);
  endtask

  task automatic t_release();
    rq();
    chk("R2 stb", 32'(smp_stb), 1);
    chk("R2 zero sample", 32'(smp), 0);
    pwr(24'hBADBAD);
    chk("R2 still reset", 32'(in_rst), 1);
    cfg(0, 4'h0);
    chk("R3 hold", 32'(in_rst), 1);
    @(negedge clk);
    chk("R3 hold idle", 32'(in_rst), 1);
    pwr(24'h123456);
    chk("R3 released", 32'(in_rst), 0);
    rq();
    chk("R3 first zero", 32'(smp), 0);
    rq();
    chk("R3 first word", 32'(smp), 32'h123456);
    chk("R3 no urun", 32'(urun), 0);
  endtask

  task automatic t_fill();
    cfg(1, 4'h0);
    cfg(0, 4'h0);
    clr_flags();
    pwr(24'h000011);
    pwr(24'h000022);
    pwr(24'h000033);
    chk("R4 no orun at 4", 32'(orun), 0);
    pwr(24'h000044);
    chk("R4 orun", 32'(orun), 1);
    @(negedge clk);
    chk("R4 orun sticky", 32'(orun), 1);
    rq(); chk("R4 rd0", 32'(smp), 0);
    rq(); chk("R4 rd1", 32'(smp), 32'h11);
    rq(); chk("R4 rd2", 32'(smp), 32'h22);
    rq(); chk("R4 rd3", 32'(smp), 32'h33);
    chk("R5 no urun yet", 32'(urun), 0);
    rq();
    chk("R5 urun", 32'(urun), 1);
    chk("R5 repeat", 32'(smp), 32'h33);
    @(negedge clk);
    chk("R5 urun sticky", 32'(urun), 1);
    clr_flags();
    chk("R5 urun cleared", 32'(urun), 0);
    chk("R4 orun cleared", 32'(orun), 0);
    pwr(24'h000055);
    rq();
    chk("R5 pointer held", 32'(smp), 32'h55);
    chk("R5 no new urun", 32'(urun), 0);
  endtask

  task automatic t_zero_lock();
    cfg(0, 4'h1);
    chk("R7 locked", 32'(src), 0);
    cfg(1, 4'h1);
    chk("R7 set with reset", 32'(src), 1);
    cfg(0, 4'h1);
    pwr(24'h0000AA);
    chk("R6 released", 32'(in_rst), 0);
    for (int i = 0; i < 5; i++) pwr(24'(i + 1));
    for (int i = 0; i < 6; i++) begin
      rq();
      chk("R6 zero data", 32'(smp), 0);
    end
    chk("R6 no urun", 32'(urun), 0);
    chk("R6 no orun", 32'(orun), 0);
    cfg(0, 4'h0);
    chk("R7 locked normal", 32'(src), 1);
  endtask

  task automatic t_copy();
    cfg(1, 4'b1010);
    cfg(0, 4'b1010);
    clr_flags();
    rx_smp = '0;
    rx_smp[2*DW +: DW] = 24'hC0FFEE;
    rx_smp[1*DW +: DW] = 24'h0BAD01;
    pwr(24'h777777);
    chk("R8 proc ignored", 32'(in_rst), 1);
    rx_stb = 4'b0010; @(negedge clk); rx_stb = '0;
    chk("R8 wrong chan ignored", 32'(in_rst), 1);
    rx_stb = 4'b0100; @(negedge clk); rx_stb = '0;
    chk("R8 released", 32'(in_rst), 0);
    rq(); chk("R8 zero first", 32'(smp), 0);
    rq(); chk("R8 copy data", 32'(smp), 32'hC0FFEE);
    pwr(24'h777777);
    rq();
    chk("R8 proc not queued", 32'(urun), 1);
    chk("R8 repeat", 32'(smp), 32'hC0FFEE);
    clr_flags();
  endtask

  task automatic t_valid();
    ctl_vinv = 1; cfg(ctl_rst, ctl_src);
    rq(); chk("R9 invalid", 32'(v), 1);
    ctl_vinv = 0; cfg(ctl_rst, ctl_src);
    rq(); chk("R9 valid", 32'(v), 0);
  endtask

  task automatic t_user();
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic e;
        u_rx = p[0]; u_gen = p[1];
        ctl_usel = 2'(c); cfg(ctl_rst, ctl_src);
        e = (c == 1) ? u_rx : (c == 3) ? u_gen : 1'b0;
        chk("R10 user", 32'(u), 32'(e));
      end
    end
  endtask

  task automatic t_osel();
    logic [NCH-1:0] pats [2] = '{4'b0101, 4'b1010};
    for (int pi = 0; pi < 2; pi++) begin
      ser_in = pats[pi]; tx_ser = pi[0];
      for (int c = 0; c < 8; c++) begin
        logic e;
        ctl_osel = 3'(c); cfg(ctl_rst, ctl_src);
        e = (c >= 1 && c <= 4) ? ser_in[c-1] : (c == 5) ? tx_ser : 1'b0;
        chk("R11 out", 32'(ser), 32'(e));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_release();
    t_fill();
    t_zero_lock();
    t_copy();
    t_valid();
    t_user();
    t_osel();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule